// File: doc/BRIEF.md
# Descriptor-Driven Transmit Byte Streamer

This block accepts one simplified transmit descriptor at a time and plays out the buffer it names as a byte-wide valid/ready stream. A descriptor gives a buffer start address, a byte count and two framing flags. When the start flag is set, the first beat taken from the buffer is tagged start-of-frame. When the end flag is set, the final beat taken from the buffer is tagged end-of-frame. Chaining descriptors whose flags are clear in the middle lets one frame cover several buffers.

Bytes are read through a synchronous memory read port that has one cycle of latency. For each descriptor the block also produces the address of the next descriptor. This is the accepted descriptor's own address plus a stride of 16 bytes (four 32-bit words) or 32 bytes (eight words), chosen per descriptor by a select input. A descriptor with a byte count of zero produces no beats. It completes at once, and it is flagged as malformed if it carries either framing flag. The descriptor fields are inputs only: the block never writes a length back.

The controller has four states. `ST_IDLE` waits for a descriptor. `ST_READ` issues one memory read. `ST_CAPT` latches the returned byte. `ST_SEND` offers the byte on the stream. The transitions are:
- accept (ST_IDLE to ST_READ, non-zero count);
- skip (ST_IDLE to ST_IDLE, zero count, with done and possibly error);
- issue (ST_READ to ST_CAPT);
- latch (ST_CAPT to ST_SEND);
- stall (ST_SEND to ST_SEND while ready is low);
- advance (ST_SEND to ST_READ on acceptance of a non-final byte);
- finish (ST_SEND to ST_IDLE on acceptance of the final byte).

Top module: `txd_streamer`

## Requirements
- R1: For a descriptor with count N > 0, exactly N beats are accepted on the stream. Beat k carries the memory byte at buffer address + k.
- R2: `out_sof` is high on beat 0 of a descriptor whose start flag is set, and low on every other beat.
- R3: `out_eof` is high on beat N-1 of a descriptor whose end flag is set, and low on every other beat. A descriptor with neither flag set, in the middle of a frame, produces no markers.
- R4: From the cycle after a descriptor is accepted until the next acceptance, `next_desc_addr` equals the accepted `desc_addr` plus 16 when `desc_wide` is 0, and plus 32 when `desc_wide` is 1.
- R5: A count of up to 2^LEN_W-1 bytes (8191 by default) is streamed in full.
- R6: A count of zero produces no beats. `done` pulses in the cycle after acceptance, and `err` pulses in that same cycle only when the start or end flag is set.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_sof` and `out_eof` hold their values into the next cycle.
- R8: `done` is high for exactly one cycle, in the cycle after the final beat is accepted. `desc_ready` is already high in that cycle.
- R9: While a descriptor is in progress, `desc_ready` is low and `desc_valid` has no effect on the stream.
- R10: After reset, `desc_ready` is 1, and `out_valid`, `mem_rd_en`, `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block can take a descriptor |
| desc_addr | input | ADDR_W | Address of the offered descriptor itself |
| desc_buf | input | ADDR_W | Buffer start address |
| desc_len | input | LEN_W | Buffer byte count |
| desc_first | input | 1 | Start-of-frame flag |
| desc_last | input | 1 | End-of-frame flag |
| desc_wide | input | 1 | 1 selects a 32-byte stride, 0 selects 16 bytes |
| next_desc_addr | output | ADDR_W | Address of the following descriptor |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Memory read byte address |
| mem_rd_data | input | 8 | Read data, one cycle after the strobe |
| out_valid | output | 1 | Stream beat valid |
| out_ready | input | 1 | Stream sink ready |
| out_data | output | 8 | Stream byte |
| out_sof | output | 1 | Start-of-frame marker |
| out_eof | output | 1 | End-of-frame marker |
| done | output | 1 | Descriptor completed pulse |
| err | output | 1 | Zero-count descriptor carried a flag |

## Verification
The hardest situation to reach from the ports is a new descriptor that arrives while a buffer is still streaming, with the final beat also held under backpressure. The stimulus raises `desc_valid` in the middle of a transfer while `out_ready` follows a stall mask. It then checks that the byte sequence and markers are unchanged, and that `done` appears only once, after the last stalled beat is accepted. Zero-count descriptors with and without flags, and a maximum-length buffer, reach the remaining edges.

// File: rtl/txs_pkg.sv
package txs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_CAPT = 2'd2,
        ST_SEND = 2'd3
    } txs_state_e;
endpackage

// File: rtl/txs_stride.sv
module txs_stride #(
    parameter int ADDR_W       = 32,
    parameter int WORD_BYTES   = 4,
    parameter int NARROW_WORDS = 4,
    parameter int WIDE_WORDS   = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic              wide,
    output logic [ADDR_W-1:0] next_addr
);
    localparam int NARROW_BYTES = WORD_BYTES * NARROW_WORDS;
    localparam int WIDE_BYTES   = WORD_BYTES * WIDE_WORDS;

    logic [ADDR_W-1:0] step;
    assign step      = wide ? ADDR_W'(WIDE_BYTES) : ADDR_W'(NARROW_BYTES);
    assign next_addr = base + step;
endmodule

// File: rtl/txs_tracker.sv
module txs_tracker #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [LEN_W-1:0]  ld_len,
    input  logic              ld_first,
    input  logic              ld_last,
    input  logic              step,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              final_beat,
    output logic              sof,
    output logic              eof
);
    logic [LEN_W-1:0] remain_q;
    logic             sof_pend_q;
    logic             last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr    <= '0;
            remain_q   <= '0;
            sof_pend_q <= 1'b0;
            last_q     <= 1'b0;
        end else if (load) begin
            rd_addr    <= ld_addr;
            remain_q   <= ld_len;
            sof_pend_q <= ld_first;
            last_q     <= ld_last;
        end else if (step) begin
            rd_addr    <= rd_addr + ADDR_W'(1);
            remain_q   <= remain_q - LEN_W'(1);
            sof_pend_q <= 1'b0;
        end
    end

    assign final_beat = (remain_q == LEN_W'(1));
    assign sof        = sof_pend_q;
    assign eof        = last_q && final_beat;
endmodule

// File: rtl/txs_fsm.sv
module txs_fsm
    import txs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic desc_valid,
    input  logic len_zero,
    input  logic flagged,
    input  logic final_beat,
    input  logic out_ready,
    output logic desc_ready,
    output logic mem_rd_en,
    output logic cap_en,
    output logic out_valid,
    output logic load,
    output logic step,
    output logic done,
    output logic err
);
    txs_state_e state_q, state_d;
    logic       skip_now;
    logic       finish_now;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= skip_now || finish_now;
            err     <= skip_now && flagged;
        end
    end

    always_comb begin
        state_d    = state_q;
        desc_ready = 1'b0;
        mem_rd_en  = 1'b0;
        cap_en     = 1'b0;
        out_valid  = 1'b0;
        load       = 1'b0;
        step       = 1'b0;
        skip_now   = 1'b0;
        finish_now = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                desc_ready = 1'b1;
                if (desc_valid) begin
                    if (len_zero) begin
                        skip_now = 1'b1;
                    end else begin
                        load    = 1'b1;
                        state_d = ST_READ;
                    end
                end
            end
            ST_READ: begin
                mem_rd_en = 1'b1;
                state_d   = ST_CAPT;
            end
            ST_CAPT: begin
                cap_en  = 1'b1;
                state_d = ST_SEND;
            end
            ST_SEND: begin
                out_valid = 1'b1;
                if (out_ready) begin
                    step = 1'b1;
                    if (final_beat) begin
                        finish_now = 1'b1;
                        state_d    = ST_IDLE;
                    end else begin
                        state_d = ST_READ;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/txd_streamer.sv
module txd_streamer #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic [ADDR_W-1:0] desc_buf,
    input  logic [LEN_W-1:0]  desc_len,
    input  logic              desc_first,
    input  logic              desc_last,
    input  logic              desc_wide,
    output logic [ADDR_W-1:0] next_desc_addr,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_sof,
    output logic              out_eof,
    output logic              done,
    output logic              err
);
    logic              load, step, cap_en, final_beat;
    logic              accept;
    logic [ADDR_W-1:0] stride_next;

    txs_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .desc_valid (desc_valid),
        .len_zero   (desc_len == '0),
        .flagged    (desc_first || desc_last),
        .final_beat (final_beat),
        .out_ready  (out_ready),
        .desc_ready (desc_ready),
        .mem_rd_en  (mem_rd_en),
        .cap_en     (cap_en),
        .out_valid  (out_valid),
        .load       (load),
        .step       (step),
        .done       (done),
        .err        (err)
    );

    txs_tracker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .ld_addr    (desc_buf),
        .ld_len     (desc_len),
        .ld_first   (desc_first),
        .ld_last    (desc_last),
        .step       (step),
        .rd_addr    (mem_rd_addr),
        .final_beat (final_beat),
        .sof        (out_sof),
        .eof        (out_eof)
    );

    txs_stride #(.ADDR_W(ADDR_W)) u_stride (
        .base      (desc_addr),
        .wide      (desc_wide),
        .next_addr (stride_next)
    );

    assign accept = desc_valid && desc_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_desc_addr <= '0;
            out_data       <= '0;
        end else begin
            if (accept) next_desc_addr <= stride_next;
            if (cap_en) out_data <= mem_rd_data;
        end
    end
endmodule

// File: rtl/txs_checker.sv
module txs_checker #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              desc_valid,
    input logic              desc_ready,
    input logic [ADDR_W-1:0] desc_addr,
    input logic [LEN_W-1:0]  desc_len,
    input logic              desc_first,
    input logic              desc_last,
    input logic              desc_wide,
    input logic [ADDR_W-1:0] next_desc_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [7:0]        out_data,
    input logic              out_sof,
    input logic              out_eof,
    input logic              done,
    input logic              err
);
    logic [LEN_W-1:0] beats_q;
    logic [LEN_W-1:0] len_q;
    logic             acc;

    assign acc = desc_valid && desc_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beats_q <= '0;
            len_q   <= '0;
        end else if (acc) begin
            beats_q <= '0;
            len_q   <= desc_len;
        end else if (out_valid && out_ready) begin
            beats_q <= beats_q + LEN_W'(1);
        end
    end

    p_count_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (beats_q == len_q));

    p_sof_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sof) |-> (beats_q == '0));

    p_eof_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eof) |=> done);

    p_stride_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (next_desc_addr == $past(desc_addr) +
                 ($past(desc_wide) ? ADDR_W'(32) : ADDR_W'(16))));

    p_zero_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && desc_len == '0 && (desc_first || desc_last)) |=> (err && done));

    p_err_needs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                      $stable(out_sof) && $stable(out_eof)));

    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(desc_ready && out_valid));
endmodule

bind txd_streamer txs_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .desc_valid     (desc_valid),
    .desc_ready     (desc_ready),
    .desc_addr      (desc_addr),
    .desc_len       (desc_len),
    .desc_first     (desc_first),
    .desc_last      (desc_last),
    .desc_wide      (desc_wide),
    .next_desc_addr (next_desc_addr),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .out_data       (out_data),
    .out_sof        (out_sof),
    .out_eof        (out_eof),
    .done           (done),
    .err            (err)
);

// File: tb/sim_txd_streamer.sv
module sim_txd_streamer;
    localparam int AW = 32;
    localparam int LW = 13;

    typedef struct packed {
        logic [15:0] dsc;
        logic [15:0] bufa;
        logic [12:0] len;
        logic        first;
        logic        last;
        logic        wide;
        logic [7:0]  rdy;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{16'h0100, 16'h2000, 13'd5, 1'b1, 1'b1, 1'b0, 8'hFF},
        '{16'h0110, 16'h2100, 13'd4, 1'b1, 1'b0, 1'b1, 8'hA5},
        '{16'h0130, 16'h2200, 13'd3, 1'b0, 1'b0, 1'b0, 8'h6D},
        '{16'h0140, 16'h2300, 13'd6, 1'b0, 1'b1, 1'b1, 8'h33},
        '{16'h0160, 16'h20FE, 13'd4, 1'b1, 1'b1, 1'b0, 8'hF1},
        '{16'h0170, 16'h3000, 13'd1, 1'b1, 1'b1, 1'b1, 8'h0F},
        '{16'h0190, 16'h3100, 13'd2, 1'b0, 1'b1, 1'b0, 8'h81}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          desc_valid = 1'b0;
    logic          desc_ready;
    logic [AW-1:0] desc_addr = '0;
    logic [AW-1:0] desc_buf = '0;
    logic [LW-1:0] desc_len = '0;
    logic          desc_first = 1'b0;
    logic          desc_last = 1'b0;
    logic          desc_wide = 1'b0;
    logic [AW-1:0] next_desc_addr;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [7:0]    mem_rd_data;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [7:0]    out_data;
    logic          out_sof;
    logic          out_eof;
    logic          done;
    logic          err;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [7:0] memf(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= memf(mem_rd_addr);
    end

    txd_streamer #(.ADDR_W(AW), .LEN_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_addr(desc_addr), .desc_buf(desc_buf), .desc_len(desc_len),
        .desc_first(desc_first), .desc_last(desc_last), .desc_wide(desc_wide),
        .next_desc_addr(next_desc_addr), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof), .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_desc(input vec_t v, input bit inject);
        int   k = 0;
        bit   hold = 1'b0;
        logic [7:0] hd = '0;
        logic hs = 1'b0, he = 1'b0;
        int   cyc = 0;
        bit   got_done = 1'b0;
        @(negedge clk);
        while (!desc_ready) @(negedge clk);
        desc_valid = 1'b1;
        desc_addr  = AW'(v.dsc);
        desc_buf   = AW'(v.bufa);
        desc_len   = v.len;
        desc_first = v.first;
        desc_last  = v.last;
        desc_wide  = v.wide;
        for (int it = 0; it < 40000; it++) begin
            @(negedge clk);
            desc_valid = 1'b0;
            if (done) begin got_done = 1'b1; break; end
            if (hold) begin
                // R7: stalled beat held
                chk(out_valid && out_data == hd && out_sof == hs && out_eof == he,
                    "R7 hold", {out_valid, out_data}, {1'b1, hd});
            end
            if (inject && it == 2) begin
                // R9: a descriptor offered while busy is refused
                chk(desc_ready == 1'b0, "R9 busy", desc_ready, 0);
                desc_valid = 1'b1;
                desc_buf   = 32'hDEAD_0000;
                desc_len   = 13'd1;
                desc_addr  = 32'h0000_0F00;
            end
            out_ready = v.rdy[cyc & 7];
            cyc++;
            hold = 1'b0;
            if (out_valid) begin
                if (out_ready) begin
                    chk(out_data == memf(AW'(v.bufa) + AW'(k)), "R1 data", out_data,
                        memf(AW'(v.bufa) + AW'(k)));
                    chk(out_sof == (v.first && k == 0), "R2 sof", out_sof, v.first && k == 0);
                    chk(out_eof == (v.last && k == int'(v.len) - 1), "R3 eof", out_eof,
                        v.last && k == int'(v.len) - 1);
                    k++;
                end else begin
                    hold = 1'b1; hd = out_data; hs = out_sof; he = out_eof;
                end
            end
        end
        out_ready = 1'b0;
        chk(got_done, "R8 done seen", got_done, 1);
        // R1 / R5: exact beat count
        chk(k == int'(v.len), "R1 count", k, v.len);
        chk(err == ((v.len == 0) && (v.first || v.last)), "R6 err", err,
            (v.len == 0) && (v.first || v.last));
        chk(desc_ready == 1'b1, "R8 ready with done", desc_ready, 1);
        chk(next_desc_addr == AW'(v.dsc) + (v.wide ? AW'(32) : AW'(16)), "R4 stride",
            next_desc_addr, AW'(v.dsc) + (v.wide ? AW'(32) : AW'(16)));
        @(negedge clk);
        chk(done == 1'b0, "R8 single pulse", done, 0);
        chk(err == 1'b0, "R6 err pulse", err, 0);
    endtask

    initial begin
        vec_t d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        chk(desc_ready == 1'b1, "R10 desc_ready", desc_ready, 1);
        chk(out_valid == 1'b0, "R10 out_valid", out_valid, 0);
        chk(mem_rd_en == 1'b0, "R10 mem_rd_en", mem_rd_en, 0);
        chk(done == 1'b0 && err == 1'b0, "R10 done/err", {done, err}, 0);
        for (int i = 0; i < NV; i++) run_desc(VECS[i], i == 1 || i == 3);
        // R6: zero count, flagged and unflagged
        d = '{16'h0200, 16'h4000, 13'd0, 1'b1, 1'b0, 1'b1, 8'hFF};
        run_desc(d, 1'b0);
        d = '{16'h0220, 16'h4000, 13'd0, 1'b0, 1'b0, 1'b0, 8'hFF};
        run_desc(d, 1'b0);
        d = '{16'h0230, 16'h4000, 13'd0, 1'b0, 1'b1, 1'b0, 8'hFF};
        run_desc(d, 1'b0);
        // R5: maximum-length buffer
        d = '{16'h0300, 16'h5000, 13'd8191, 1'b1, 1'b1, 1'b1, 8'hFF};
        run_desc(d, 1'b1);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule